// File: doc/BRIEF.md
# Reset-Qualified Chip-Enable Gate

This block sits between a processor's active-low memory chip-enable and a battery-backed or otherwise protected RAM. In normal operation it is transparent: the memory sees every chip-enable transition the processor makes. When the supply supervisor asserts its active-low system reset, the block shuts the path and holds the memory's chip-enable inactive (high). This keeps a processor that is browning out from writing garbage into the RAM.

Shutting the path abruptly could cut a legitimate write short. So when reset is first seen asserted while the chip-enable is active, the block keeps conducting for a bounded grace period. The path closes at the earliest of two events: the chip-enable input being sampled high, or the grace period running out. Once closed, the path stays closed until reset is released. Reset is sampled on the clock, and the grace period is a parameter counted in clock cycles. A status output reports whether the path is conducting.

Top module: `ce_guard`

## Requirements
- R1: At any clock edge that samples `rst_n` high, `gate_on` is 1 after that edge. While `gate_on` is 1, `ce_out_n` equals `ce_in_n` combinationally.
- R2: While `gate_on` is 0, `ce_out_n` is 1 whatever `ce_in_n` does.
- R3: If an edge samples `rst_n` low and `ce_in_n` high while the gate is conducting, `gate_on` is 0 after that edge.
- R4: If the first edge that samples `rst_n` low also samples `ce_in_n` low, the gate keeps conducting after that edge, and `ce_out_n` stays low while the input stays low.
- R5: During the grace window, the first edge that samples `ce_in_n` high closes the gate. The gate stays closed even if the input falls again before the window would have ended.
- R6: With the input held low, the gate conducts for exactly `GRACE_CYC` cycles after the first low-reset edge. It is closed after the edge that is `GRACE_CYC` edges later.
- R7: Once closed, the gate stays closed for as long as edges sample `rst_n` low. It reopens after the first edge that samples `rst_n` high. This also applies when reset is released during the grace window.
- R8: After reset has been held low for several edges with `ce_in_n` high, `gate_on` is 0 and `ce_out_n` is 1. This is the state the block starts in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low system reset from the supply supervisor |
| ce_in_n | input | 1 | Active-low chip-enable from the processor |
| ce_out_n | output | 1 | Gated active-low chip-enable to the memory |
| gate_on | output | 1 | 1 while the path is conducting |

## Verification
Reset assertion is tried with the chip-enable inactive, and this is what separates the immediate close from the grace path. With the chip-enable active, the input's return to high is swept over every cycle of the grace window and one cycle past it. Each return is a single-cycle high pulse followed by low again. This distinguishes an early close caused by the input from a close caused by expiry, and it shows whether a later fall is wrongly passed through. Reset is also released from both the closed state and the middle of the grace window, and pass-through is tried with both input levels.

// File: rtl/ce_guard.sv
module ce_guard #(
  parameter int GRACE_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_in_n,
  output logic ce_out_n,
  output logic gate_on
);
  localparam int CW = (GRACE_CYC > 1) ? $clog2(GRACE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(GRACE_CYC - 1);

  typedef enum logic [1:0] {CLOSED = 2'd0, OPEN = 2'd1, GRACE = 2'd2} mode_t;

  mode_t mode, mode_nx;
  logic [CW-1:0] cnt, cnt_nx;

  always_comb begin
    mode_nx = CLOSED;
    cnt_nx  = '0;
    if (rst_n) mode_nx = OPEN;
    else begin
      case (mode)
        OPEN:  if (!ce_in_n) mode_nx = GRACE;
        GRACE: if (!ce_in_n && cnt != LAST) begin
                 mode_nx = GRACE;
                 cnt_nx  = cnt + 1'b1;
               end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    mode <= mode_nx;
    cnt  <= cnt_nx;
  end

  assign gate_on  = (mode == OPEN) || (mode == GRACE);
  assign ce_out_n = gate_on ? ce_in_n : 1'b1;
endmodule

module ce_guard_chk #(
  parameter int GRACE_CYC = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic ce_in_n,
  input logic ce_out_n,
  input logic gate_on
);
  logic armed = 1'b0;
  int unsigned lowrun = 0;

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b1;
    if (rst_n) lowrun <= 0;
    else if (lowrun <= GRACE_CYC) lowrun <= lowrun + 1;
  end

  a_r1_open_after_release: assert property (@(posedge clk) disable iff (!armed)
    rst_n |=> gate_on);
  a_r1_passes_input: assert property (@(posedge clk) disable iff (!armed)
    gate_on |-> (ce_out_n == ce_in_n));
  a_r2_blocked_high: assert property (@(posedge clk) disable iff (!armed)
    !gate_on |-> ce_out_n);
  a_r3_close_on_high: assert property (@(posedge clk) disable iff (!armed)
    (gate_on && !rst_n && ce_in_n) |=> !gate_on);
  a_r4_grace_starts: assert property (@(posedge clk) disable iff (!armed)
    (gate_on && !rst_n && !ce_in_n && lowrun == 0) |=> gate_on);
  a_r6_grace_bounded: assert property (@(posedge clk) disable iff (!armed)
    (lowrun > GRACE_CYC) |-> !gate_on);
  a_r7_stays_closed: assert property (@(posedge clk) disable iff (!armed)
    (!gate_on && !rst_n) |=> !gate_on);
endmodule

bind ce_guard ce_guard_chk #(.GRACE_CYC(GRACE_CYC)) u_chk (.*);

// File: tb/ce_guard_bench.sv
module ce_guard_bench;
  localparam int G = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_in_n = 1'b1;
  logic ce_out_n, gate_on;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ce_guard #(.GRACE_CYC(G)) u_ce_guard (
    .clk(clk), .rst_n(rst_n), .ce_in_n(ce_in_n),
    .ce_out_n(ce_out_n), .gate_on(gate_on)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic exp_on, input logic exp_out);
    #1;
    checks++;
    if (gate_on !== exp_on || ce_out_n !== exp_out) begin
      errors++;
      $display("FAIL %s: gate_on=%b ce_out_n=%b expected gate_on=%b ce_out_n=%b",
               req, gate_on, ce_out_n, exp_on, exp_out);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R8: start-up with reset held low, chip-enable idle
    @(negedge clk);
    for (int i = 0; i < 4; i++) step();
    chk("R8 idle reset", 1'b0, 1'b1);
    ce_in_n = 1'b0;
    chk("R2 blocked low input", 1'b0, 1'b1);

    // R1: release and pass-through of both levels
    rst_n = 1'b1;
    chk("R7 closed until edge", 1'b0, 1'b1);
    step();
    chk("R1 pass low", 1'b1, 1'b0);
    ce_in_n = 1'b1;
    chk("R1 pass high", 1'b1, 1'b1);

    // R3: reset with input inactive closes at once
    rst_n = 1'b0;
    chk("R1 open before reset edge", 1'b1, 1'b1);
    step();
    chk("R3 immediate close", 1'b0, 1'b1);
    for (int i = 0; i < G + 3; i++) begin
      ce_in_n = i[0];
      step();
      chk("R7 held closed", 1'b0, 1'b1);
    end
    rst_n = 1'b1;
    step();

    // R4/R5/R6: sweep the single-cycle high pulse over the grace window
    for (int k = 1; k <= G + 1; k++) begin
      bit hs;
      ce_in_n = 1'b0;
      step();
      chk("R1 open before sweep", 1'b1, 1'b0);
      rst_n = 1'b0;
      step();
      hs = 1'b0;
      for (int j = 0; j <= G + 2; j++) begin
        logic e_on;
        e_on = (!hs && j < G);
        ce_in_n = (j + 1 == k);
        if (j == 0) chk("R4 grace start", e_on, e_on ? ce_in_n : 1'b1);
        else if (hs) chk("R5 closed after input high", e_on, e_on ? ce_in_n : 1'b1);
        else chk("R6 grace window count", e_on, e_on ? ce_in_n : 1'b1);
        step();
        if (ce_in_n) hs = 1'b1;
      end
      ce_in_n = 1'b1;
      rst_n = 1'b1;
      step();
      chk("R7 reopen after sweep", 1'b1, 1'b1);
    end

    // R7: release in the middle of grace
    ce_in_n = 1'b0;
    rst_n = 1'b0;
    step();
    step();
    chk("R4 still in grace", 1'b1, 1'b0);
    rst_n = 1'b1;
    step();
    chk("R7 release during grace", 1'b1, 1'b0);
    rst_n = 1'b0;
    for (int i = 0; i < G + 1; i++) step();
    chk("R6 expiry with input low", 1'b0, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule